// File: doc/BRIEF.md
# Keypad Wake-Up Interrupt Logic

This block watches an 8-bit input port for key closures. A key pulls its pin low. A mask register chooses which pins may raise the event. Once a selected pin has been seen low through a two-stage synchronizer, and the block-level enable is on, a sticky flag is set. Only a software write clears the flag. The flag drives the interrupt request when the block-level enable is set.

A second path lets the event end a low-power state. While the sleep indicator is high, the wake output is formed combinationally from the raw pins, the mask and the enable. It therefore works even when the clock is stopped. A pending interrupt also drives wake while the sleep indicator is high. Software decodes which key was pressed by polling the port, and it handles debouncing.

The flag sits at bit 7 of a status register. Bits 6..0 of that register are plain read/write storage.

Top module: `kbd_wake`

## Requirements
- R1: After reset the mask reads 0x00, the status register reads 0x00, and irq_o and wake_o are low.
- R2: A write with mask_we loads wdata into the mask. rdata shows the mask while mask_re is high. mask_re has priority over stat_re. rdata is 0x00 when neither read strobe is high.
- R3: Suppose an enabled pin is driven low in some cycle while en_i is high. Then the flag is set at the third rising clock edge after that, because of the two synchronizer stages. A low pin whose mask bit is 0 never sets the flag.
- R4: While en_i is low, no pin sets the flag.
- R5: The flag stays set after every pin returns high.
- R6: A status write with wdata[7] = 0 clears the flag. A status write with wdata[7] = 1 leaves the flag unchanged.
- R7: If a set condition and a clearing status write fall on the same edge, the flag ends up set.
- R8: A status write loads wdata[6:0] into status bits 6..0. These bits read back unchanged, and no other event changes them.
- R9: irq_o is high exactly when the flag is set and en_i is high. Lowering en_i does not clear the flag.
- R10: wake_o is high when sleep_i and en_i are both high, and either the flag is set or a raw pin is low where its mask bit is 1. The raw-pin path needs no clock edge. wake_o is low while sleep_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Port pins, a pressed key reads 0 |
| wdata | input | 8 | Register write data |
| mask_we | input | 1 | Write strobe for the mask register |
| stat_we | input | 1 | Write strobe for the status register |
| mask_re | input | 1 | Read strobe for the mask register |
| stat_re | input | 1 | Read strobe for the status register |
| en_i | input | 1 | Block-level enable |
| sleep_i | input | 1 | Idle or power-down indicator |
| rdata | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The directed patterns come first.
- A low pin outside the mask separates masking from detection.
- A selected pin held low and then released separates latching from plain level following.
- Clearing writes placed on the same edges as a pending set show which of the two wins.
- The same selected-pin pattern with the enable off separates gating of the set from gating of the request.

Constrained-random pins are then biased toward a released port, with sparse strobes and toggling enable and sleep. They are compared each cycle against a bench model of the synchronizer and the flag. Comparing wake_o straight after each pin change, before any edge, separates the raw combinational wake path from the synchronized one.

// File: rtl/kbd_wake.sv
module kbd_wake #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] wdata,
  input  logic         mask_we,
  input  logic         stat_we,
  input  logic         mask_re,
  input  logic         stat_re,
  input  logic         en_i,
  input  logic         sleep_i,
  output logic [W-1:0] rdata,
  output logic         irq_o,
  output logic         wake_o
);
  localparam int FB = W - 1;

  logic [W-1:0]  sync1, sync2, mask_q;
  logic [FB-1:0] stat_low;
  logic          flag_q, flag_d, hit, clr;

  assign hit    = en_i & |(~sync2 & mask_q);
  assign clr    = stat_we & ~wdata[FB];
  assign flag_d = hit | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= '1;
      sync2    <= '1;
      mask_q   <= '0;
      stat_low <= '0;
      flag_q   <= 1'b0;
    end else begin
      sync1  <= pin_i;
      sync2  <= sync1;
      flag_q <= flag_d;
      if (mask_we) mask_q <= wdata;
      if (stat_we) stat_low <= wdata[FB-1:0];
    end
  end

  assign irq_o  = flag_q & en_i;
  assign wake_o = sleep_i & en_i & (flag_q | |(~pin_i & mask_q));
  assign rdata  = mask_re ? mask_q : (stat_re ? {flag_q, stat_low} : '0);

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(wdata));

  // R6
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(stat_we) && !$past(wdata[FB]));

  // R4
  flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(en_i));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && clr |=> flag_q);

  // R8
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> $stable(stat_low));

  // R10
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |-> !wake_o);
endmodule

// File: tb/sim_kbd_wake.sv
module sim_kbd_wake;
  logic       clk = 0, rst_n = 0;
  logic [7:0] pin_i = 8'hFF, wdata = 0;
  logic       mask_we = 0, stat_we = 0, mask_re = 0, stat_re = 0, en_i = 0, sleep_i = 0;
  logic [7:0] rdata;
  logic       irq_o, wake_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_s1 = 8'hFF, m_s2 = 8'hFF, m_mask = 0;
  logic [6:0] m_low = 0;
  logic       m_flag = 0;

  kbd_wake u0 (.clk, .rst_n, .pin_i, .wdata, .mask_we, .stat_we, .mask_re, .stat_re,
               .en_i, .sleep_i, .rdata, .irq_o, .wake_o);

  always #2 clk = ~clk;

  function automatic logic [7:0] exp_rdata();
    if (mask_re) return m_mask;
    if (stat_re) return {m_flag, m_low};
    return 8'h00;
  endfunction

  function automatic logic exp_wake();
    return sleep_i & en_i & (m_flag | |(~pin_i & m_mask));
  endfunction

  task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(string tag);
    #1;
    check(tag, "rdata", rdata, exp_rdata());
    check(tag, "irq_o", {7'd0, irq_o}, {7'd0, m_flag & en_i});
    check(tag, "wake_o", {7'd0, wake_o}, {7'd0, exp_wake()});
    @(posedge clk);
    begin
      logic nf;
      nf = m_flag;
      if (stat_we && !wdata[7]) nf = 1'b0;
      if (en_i && |(~m_s2 & m_mask)) nf = 1'b1;
      m_flag = nf;
      if (stat_we) m_low = wdata[6:0];
      if (mask_we) m_mask = wdata;
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
    @(negedge clk);
    mask_we = 0; stat_we = 0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc("R1");
    mask_re = 1; cyc("R1");
    mask_re = 0; stat_re = 1; cyc("R1");
    stat_re = 0;
    // R2 mask write and read, priority
    mask_we = 1; wdata = 8'h05; cyc("R2");
    mask_re = 1; cyc("R2");
    stat_re = 1; cyc("R2");
    mask_re = 0; stat_re = 0; cyc("R2");
    // R3 disabled pin ignored, then enabled pin sets at third edge
    en_i = 1; pin_i = ~8'h02;
    stat_re = 1;
    repeat (4) cyc("R3");
    pin_i = ~8'h04;
    repeat (4) cyc("R3");
    // R5 sticky
    pin_i = 8'hFF;
    repeat (3) cyc("R5");
    // R9 enable off keeps flag, drops irq
    en_i = 0; repeat (2) cyc("R9");
    en_i = 1; cyc("R9");
    // R6 write one keeps, write zero clears
    stat_we = 1; wdata = 8'hFF; cyc("R6");
    cyc("R6");
    stat_we = 1; wdata = 8'h2A; cyc("R6");
    cyc("R8");
    // R7 set wins over clear
    pin_i = ~8'h01;
    repeat (5) begin stat_we = 1; wdata = 8'h00; cyc("R7"); end
    cyc("R7");
    // R4 enable off blocks set
    en_i = 0; stat_we = 1; wdata = 8'h11; cyc("R4");
    repeat (4) cyc("R4");
    // R10 raw path while asleep
    pin_i = 8'hFF; en_i = 1; stat_we = 1; wdata = 8'h00; cyc("R10");
    sleep_i = 1; cyc("R10");
    pin_i = ~8'h04; cyc("R10");
    sleep_i = 0; cyc("R10");
    stat_re = 0;
    // random
    for (int i = 0; i < 4000; i++) begin
      pin_i   = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
      mask_we = ($urandom_range(0, 15) == 0);
      stat_we = ($urandom_range(0, 7) == 0);
      wdata   = 8'($urandom);
      mask_re = ($urandom_range(0, 3) == 0);
      stat_re = $urandom_range(0, 1) == 1;
      en_i    = ($urandom_range(0, 7) != 0);
      sleep_i = $urandom_range(0, 1) == 1;
      cyc("R3");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule